// File: doc/BRIEF.md
# Isochronous Block-Threshold Circular Buffer Controller

This block manages one isochronous channel's circular buffer inside a shared byte-wide buffer RAM. It keeps a write pointer for the receive side and a read pointer for the transmit side. From these two pointers it derives the count of valid bytes and the count of free bytes. It also produces the RAM byte address for each side. RAM arbitration and the data path are handled outside the block.

Transfers happen in whole blocks. A side raises its request, and the block grants it in the same cycle when the threshold is met. The side then moves exactly one block of bytes, one strobe per byte. Equal pointers can mean either an empty or a full buffer. A sticky full flag tells the two apart: the writer sets it and the reader clears it. Flow control selects what happens when a receive block does not fit. With flow control on, the writer is held off. With flow control off, the writer proceeds, the oldest data is overwritten, and an overflow status bit is latched.

Top module: `isob_ctrl`

## Requirements
- R1: After reset, both pointers are 0, `valid_cnt` is 0, `free_cnt` is `cfg_depth`+1, `buf_full` is 0, `wr_sts` is 000 and `rd_active` is 0.
- R2: With `cfg_fce`=1, `wr_gnt` is high in a cycle exactly when `wr_req` is high, no write block is in progress, and `free_cnt` ≥ `cfg_blk`+1.
- R3: `rd_gnt` is high in a cycle exactly when `rd_req` is high, no read block is in progress, and `valid_cnt` ≥ `cfg_blk`+1.
- R4: A granted block accepts exactly `cfg_blk`+1 byte strobes, and each accepted strobe advances its pointer by one. `wr_sts[0]` (write active) and `rd_active` are high from the edge after the grant until the edge of the last strobe. Strobes outside a block are ignored. A read strobe is also ignored when `valid_cnt` is 0.
- R5: `wr_addr` equals (`cfg_base` + write pointer) mod 2^14, and `rd_addr` equals (`cfg_base` + read pointer) mod 2^14. A pointer at `cfg_depth` wraps to 0.
- R6: `valid_cnt` equals (write pointer − read pointer) mod (`cfg_depth`+1). When the pointers are equal, it is `cfg_depth`+1 if the last change came from the writer and 0 otherwise. `free_cnt` is `cfg_depth`+1 − `valid_cnt`. `buf_full` is high exactly when `valid_cnt` is `cfg_depth`+1.
- R7: An accepted write strobe and an accepted read strobe in the same cycle leave `valid_cnt` unchanged.
- R8: With `cfg_fce`=0, a write request with no block in progress is always granted. If `free_cnt` < `cfg_blk`+1 at that grant, `wr_sts[2]` (overflow) is set and stays set until reset. A write into a full buffer, with no accepted read in the same cycle, also advances the read pointer, so the buffer stays full.
- R9: A `cmd_err` pulse sets `wr_sts[1]` (protocol error), which stays set until reset.
- R10: `cfg_ok` is high exactly when `cfg_depth`+1 ≥ 3·(`cfg_blk`+1) and `cfg_depth`+1 is a whole multiple of `cfg_blk`+1.
- R11: A side that has a block in progress is not granted again until that block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 14 | Buffer base byte address in the RAM |
| cfg_depth | input | 13 | Buffer size in bytes minus one |
| cfg_blk | input | 9 | Block length in bytes minus one |
| cfg_fce | input | 1 | Flow control enable for the receive side |
| wr_req | input | 1 | Receive side asks to start a write block |
| wr_gnt | output | 1 | Write block start granted (same cycle) |
| wr_strb | input | 1 | One byte written this cycle |
| wr_addr | output | 14 | RAM address of the next byte to write |
| rd_req | input | 1 | Transmit side asks to start a read block |
| rd_gnt | output | 1 | Read block start granted (same cycle) |
| rd_strb | input | 1 | One byte read this cycle |
| rd_addr | output | 14 | RAM address of the next byte to read |
| cmd_err | input | 1 | Command protocol error pulse |
| valid_cnt | output | 14 | Bytes held in the buffer |
| free_cnt | output | 14 | Empty bytes in the buffer |
| buf_full | output | 1 | Buffer holds `cfg_depth`+1 bytes |
| wr_sts | output | 3 | {overflow, protocol error, write active} |
| rd_active | output | 1 | Read block in progress |
| cfg_ok | output | 1 | Buffer geometry is legal |

## Verification
The bench drives the buffer until its pointers meet from both directions. A design that lost the full flag would report an empty buffer after three block writes and would then grant a further write that does not fit. Pointers are wrapped across the buffer end and across the top of the 14-bit address space. A design that wrapped at the wrong boundary would emit addresses outside the buffer. With flow control off, the bench overruns the buffer. A design that failed to push the read pointer along would report a non-full buffer or stale read addresses. Simultaneous read and write strobes, stray strobes, and repeated requests during a block are also applied. Each of these would show a miscounted level, or a second grant in the middle of a block.

// File: rtl/isob_pkg.sv
// Package: shared bit positions of the write status word.
package isob_pkg;
    localparam int WST_W      = 3;
    localparam int WST_ACTIVE = 0;
    localparam int WST_PERR   = 1;
    localparam int WST_OVF    = 2;
endpackage

// File: rtl/isob_side.sv
// One side (writer or reader) of the circular buffer.
// Holds the byte pointer, the in-block byte counter and the busy state,
// and forms the RAM address. Assumes start only when not busy, take only
// when busy, and ADDR_W > PTR_W.
module isob_side #(
    parameter int PTR_W  = 13,
    parameter int ADDR_W = 14,
    parameter int BLK_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_depth,
    input  logic [BLK_W-1:0]  cfg_blk,
    input  logic              start,
    input  logic              take,
    input  logic              bump,
    output logic              busy,
    output logic [PTR_W-1:0]  ptr,
    output logic [PTR_W-1:0]  ptr_nxt,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - PTR_W;

    logic [BLK_W-1:0] left_q;

    // Next pointer value with wrap at the last buffer byte.
    always_comb begin
        if (ptr == cfg_depth) ptr_nxt = '0;
        else                  ptr_nxt = ptr + 1'b1;
    end

    // RAM address is base plus offset, modulo the RAM size.
    always_comb addr = cfg_base + {{PAD_W{1'b0}}, ptr};

    // Pointer advances on an accepted byte or on a forced push.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr <= '0;
        else if (take || bump) ptr <= ptr_nxt;
    end

    // Block counter: loaded on start, counts bytes down to the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            left_q <= cfg_blk;
        end else if (take) begin
            if (left_q == '0) busy <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/isob_level.sv
// Fill level of the buffer from the two pointers and the sticky full flag.
// The flag is only consulted when the pointers are equal.
module isob_level #(
    parameter int PTR_W = 13,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [PTR_W-1:0] cfg_depth,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic             full_q,
    output logic             ptr_eq,
    output logic [CNT_W-1:0] size,
    output logic [CNT_W-1:0] valid,
    output logic [CNT_W-1:0] free
);
    logic [CNT_W-1:0] wz, rz;

    // Widen the pointers and form the buffer size.
    always_comb begin
        wz     = {1'b0, wptr};
        rz     = {1'b0, rptr};
        size   = {1'b0, cfg_depth} + CNT_W'(1);
        ptr_eq = (wptr == rptr);
    end

    // Valid bytes: modular distance, full flag resolves equality.
    always_comb begin
        if (ptr_eq)          valid = full_q ? size : '0;
        else if (wptr > rptr) valid = wz - rz;
        else                 valid = size - rz + wz;
        free = size - valid;
    end
endmodule

// File: rtl/isob_geom.sv
// Checks the configured geometry: at least three blocks, whole blocks only.
module isob_geom #(
    parameter int PTR_W = 13,
    parameter int BLK_W = 9,
    localparam int CNT_W = PTR_W + 1,
    localparam int PRD_W = CNT_W + 2
) (
    input  logic [CNT_W-1:0] size,
    input  logic [BLK_W-1:0] cfg_blk,
    output logic             cfg_ok
);
    logic [CNT_W-1:0] blk_len;
    logic [PRD_W-1:0] three_blk;
    logic [CNT_W-1:0] rem;

    // Block length, three-block minimum and remainder of the division.
    always_comb begin
        blk_len   = CNT_W'(cfg_blk) + CNT_W'(1);
        three_blk = PRD_W'(blk_len) * PRD_W'(3);
        rem       = size % blk_len;
        cfg_ok    = (PRD_W'(size) >= three_blk) && (rem == '0);
    end
endmodule

// File: rtl/isob_ctrl.sv
// Top: isochronous block-threshold circular buffer controller.
// Grants block starts against the fill level, keeps the sticky full flag,
// handles flow-controlled or overflowing writes and the write status.
// Assumes configuration is static while out of reset.
module isob_ctrl #(
    parameter int PTR_W  = 13,
    parameter int ADDR_W = 14,
    parameter int BLK_W  = 9,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_base,
    input  logic [PTR_W-1:0]          cfg_depth,
    input  logic [BLK_W-1:0]          cfg_blk,
    input  logic                      cfg_fce,
    input  logic                      wr_req,
    output logic                      wr_gnt,
    input  logic                      wr_strb,
    output logic [ADDR_W-1:0]         wr_addr,
    input  logic                      rd_req,
    output logic                      rd_gnt,
    input  logic                      rd_strb,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      cmd_err,
    output logic [CNT_W-1:0]          valid_cnt,
    output logic [CNT_W-1:0]          free_cnt,
    output logic                      buf_full,
    output logic [isob_pkg::WST_W-1:0] wr_sts,
    output logic                      rd_active,
    output logic                      cfg_ok
);
    import isob_pkg::*;

    logic             wr_busy, rd_busy;
    logic [PTR_W-1:0] wptr, rptr, wptr_nxt, rptr_nxt;
    logic             full_q, ptr_eq;
    logic [CNT_W-1:0] size, blk_len;
    logic             wr_fits, wr_take, rd_take, push;
    logic             ovf_q, perr_q;

    // Derived block length and the per-cycle decisions.
    always_comb begin
        blk_len = CNT_W'(cfg_blk) + CNT_W'(1);
        wr_fits = (free_cnt >= blk_len);
        wr_gnt  = wr_req && !wr_busy && (wr_fits || !cfg_fce);
        rd_gnt  = rd_req && !rd_busy && (valid_cnt >= blk_len);
        wr_take = wr_strb && wr_busy;
        rd_take = rd_strb && rd_busy && (valid_cnt != '0);
        push    = wr_take && !rd_take && ptr_eq && full_q;
    end

    isob_side #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
        .cfg_blk(cfg_blk), .start(wr_gnt), .take(wr_take), .bump(1'b0),
        .busy(wr_busy), .ptr(wptr), .ptr_nxt(wptr_nxt), .addr(wr_addr)
    );

    isob_side #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
        .cfg_blk(cfg_blk), .start(rd_gnt), .take(rd_take), .bump(push),
        .busy(rd_busy), .ptr(rptr), .ptr_nxt(rptr_nxt), .addr(rd_addr)
    );

    isob_level #(.PTR_W(PTR_W)) u_lvl (
        .cfg_depth(cfg_depth), .wptr(wptr), .rptr(rptr), .full_q(full_q),
        .ptr_eq(ptr_eq), .size(size), .valid(valid_cnt), .free(free_cnt)
    );

    isob_geom #(.PTR_W(PTR_W), .BLK_W(BLK_W)) u_geom (
        .size(size), .cfg_blk(cfg_blk), .cfg_ok(cfg_ok)
    );

    // Sticky full flag: writer sets on reaching the reader, reader clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= 1'b0;
        else if (wr_take && !rd_take && (wptr_nxt == (push ? rptr_nxt : rptr)))
            full_q <= 1'b1;
        else if (rd_take && !wr_take && (rptr_nxt == wptr))
            full_q <= 1'b0;
    end

    // Sticky status bits: overflow on an unfitting grant, protocol error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (wr_gnt && !wr_fits) ovf_q  <= 1'b1;
            if (cmd_err)            perr_q <= 1'b1;
        end
    end

    // Status outputs.
    always_comb begin
        wr_sts             = '0;
        wr_sts[WST_ACTIVE] = wr_busy;
        wr_sts[WST_PERR]   = perr_q;
        wr_sts[WST_OVF]    = ovf_q;
        rd_active          = rd_busy;
        buf_full           = ptr_eq && full_q;
    end
endmodule

// File: rtl/isob_ctrl_chk.sv
// Checker for isob_ctrl: grant thresholds, level consistency, sticky status.
module isob_ctrl_chk #(
    parameter int PTR_W  = 13,
    parameter int ADDR_W = 14,
    parameter int BLK_W  = 9,
    localparam int CNT_W = PTR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PTR_W-1:0]  cfg_depth,
    input logic [BLK_W-1:0]  cfg_blk,
    input logic              cfg_fce,
    input logic              wr_gnt,
    input logic              rd_gnt,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  valid_cnt,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              buf_full,
    input logic [2:0]        wr_sts
);
    logic [CNT_W-1:0] c_blk, c_size;
    always_comb begin
        c_blk  = CNT_W'(cfg_blk) + CNT_W'(1);
        c_size = {1'b0, cfg_depth} + CNT_W'(1);
    end

    // R2
    wr_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt && cfg_fce) |-> (free_cnt >= c_blk));
    // R3
    rd_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |-> (valid_cnt >= c_blk));
    // R6
    level_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_cnt + free_cnt) == c_size);
    // R6
    full_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> (wr_addr == rd_addr));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts[2] |=> wr_sts[2]);
    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts[1] |=> wr_sts[1]);
    // R11
    busy_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts[0] |-> !wr_gnt);
endmodule

bind isob_ctrl isob_ctrl_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_blk(cfg_blk),
    .cfg_fce(cfg_fce), .wr_gnt(wr_gnt), .rd_gnt(rd_gnt), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .valid_cnt(valid_cnt), .free_cnt(free_cnt),
    .buf_full(buf_full), .wr_sts(wr_sts)
);

// File: tb/isob_ctrl_test.sv
`timescale 1ns/1ps
module isob_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cfg_base = '0;
    logic [12:0] cfg_depth = '0;
    logic [8:0]  cfg_blk = '0;
    logic        cfg_fce = 1'b1;
    logic        wr_req = 0, wr_strb = 0, rd_req = 0, rd_strb = 0, cmd_err = 0;
    logic        wr_gnt, rd_gnt, buf_full, rd_active, cfg_ok;
    logic [13:0] wr_addr, rd_addr, valid_cnt, free_cnt;
    logic [2:0]  wr_sts;

    isob_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_depth(cfg_depth),
        .cfg_blk(cfg_blk), .cfg_fce(cfg_fce), .wr_req(wr_req), .wr_gnt(wr_gnt),
        .wr_strb(wr_strb), .wr_addr(wr_addr), .rd_req(rd_req), .rd_gnt(rd_gnt),
        .rd_strb(rd_strb), .rd_addr(rd_addr), .cmd_err(cmd_err),
        .valid_cnt(valid_cnt), .free_cnt(free_cnt), .buf_full(buf_full),
        .wr_sts(wr_sts), .rd_active(rd_active), .cfg_ok(cfg_ok)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Behavioural model state.
    int msize, mbs, mbase, mfce;
    int wp, rp, cnt, wleft, rleft;
    bit wbusy, rbusy, ovf, perr, mwg, mrg;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic compare_all();
        int mfree;
        mfree = msize - cnt;
        mwg = wr_req && !wbusy && (!mfce || mfree >= mbs);
        mrg = rd_req && !rbusy && cnt >= mbs;
        chk("R2 wr_gnt", int'(wr_gnt), int'(mwg));
        chk("R3 rd_gnt", int'(rd_gnt), int'(mrg));
        chk("R6 valid_cnt", int'(valid_cnt), cnt);
        chk("R6 free_cnt", int'(free_cnt), mfree);
        chk("R6 buf_full", int'(buf_full), int'(cnt == msize));
        chk("R5 wr_addr", int'(wr_addr), (mbase + wp) % 16384);
        chk("R5 rd_addr", int'(rd_addr), (mbase + rp) % 16384);
        chk("R4 wr active", int'(wr_sts[0]), int'(wbusy));
        chk("R4 rd_active", int'(rd_active), int'(rbusy));
        chk("R9 perr", int'(wr_sts[1]), int'(perr));
        chk("R8 ovf", int'(wr_sts[2]), int'(ovf));
        chk("R10 cfg_ok", int'(cfg_ok),
            int'(msize >= 3 * mbs && msize % mbs == 0));
    endtask

    // Drive inputs away from the edge and compare against the model.
    task automatic drive(input bit wq, input bit ws, input bit rq, input bit rs, input bit ce);
        @(negedge clk);
        wr_req = wq; wr_strb = ws; rd_req = rq; rd_strb = rs; cmd_err = ce;
        #5;
        compare_all();
    endtask

    // Advance the clock and the model by one cycle.
    task automatic tick();
        bit wt, rt;
        @(posedge clk);
        wt = wr_strb && wbusy;
        rt = rd_strb && rbusy && cnt > 0;
        if (wt) begin
            wleft--;
            if (wleft == 0) wbusy = 0;
            wp = (wp + 1) % msize;
        end
        if (rt) begin
            rleft--;
            if (rleft == 0) rbusy = 0;
            rp = (rp + 1) % msize;
        end
        if (wt && !rt) begin
            if (cnt == msize) rp = (rp + 1) % msize;
            else cnt++;
        end
        if (rt && !wt) cnt--;
        if (mwg) begin
            if (msize - cnt < mbs) ovf = 1;
            wbusy = 1; wleft = mbs;
        end
        if (mrg) begin
            rbusy = 1; rleft = mbs;
        end
        if (cmd_err) perr = 1;
    endtask

    task automatic step(input bit wq, input bit ws, input bit rq, input bit rs, input bit ce);
        drive(wq, ws, rq, rs, ce);
        tick();
    endtask

    task automatic do_reset(input int base, input int depth, input int blk, input bit fce);
        @(negedge clk);
        rst_n = 0; wr_req = 0; wr_strb = 0; rd_req = 0; rd_strb = 0; cmd_err = 0;
        cfg_base = 14'(base); cfg_depth = 13'(depth); cfg_blk = 9'(blk); cfg_fce = fce;
        mbase = base; msize = depth + 1; mbs = blk + 1; mfce = int'(fce);
        wp = 0; rp = 0; cnt = 0; wleft = 0; rleft = 0;
        wbusy = 0; rbusy = 0; ovf = 0; perr = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", int'(valid_cnt), 0);
        chk("R1 reset free", int'(free_cnt), msize);
        chk("R1 reset sts", int'(wr_sts), 0);
        chk("R1 reset full", int'(buf_full), 0);
        chk("R1 reset rd_active", int'(rd_active), 0);
        chk("R1 reset wr_addr", int'(wr_addr), base % 16384);
        rst_n = 1;
    endtask

    task automatic wr_block();
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < mbs; i++) step(0, 1, 0, 0, 0);
    endtask

    task automatic rd_block();
        step(0, 0, 1, 0, 0);
        for (int i = 0; i < mbs; i++) step(0, 0, 0, 1, 0);
    endtask

    initial begin
        // Scenario A: flow control on, 96-byte buffer, 32-byte blocks.
        do_reset(100, 95, 31, 1'b1);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0); // stray strobes
        drive(0, 0, 0, 0, 0);
        chk("R4 stray strobes ignored", int'(valid_cnt), 0);
        tick();
        step(0, 0, 1, 0, 0);                              // read on empty
        step(1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0);
        chk("R11 no regrant while busy", int'(wr_gnt), 0);
        tick();
        for (int i = 1; i < 32; i++) step(0, 1, 0, 0, 0);
        wr_block();
        wr_block();
        drive(1, 0, 0, 0, 0);
        chk("R6 full after three blocks", int'(buf_full), 1);
        chk("R2 held off when full", int'(wr_gnt), 0);
        tick();
        rd_block();
        drive(1, 0, 1, 0, 0);
        chk("R2 grant with one block free", int'(wr_gnt), 1);
        chk("R3 grant with blocks valid", int'(rd_gnt), 1);
        tick();
        for (int i = 0; i < 32; i++) step(0, 1, 0, 1, 0);
        drive(0, 0, 0, 0, 0);
        chk("R7 level kept by paired strobes", int'(valid_cnt), 64);
        tick();
        rd_block();
        rd_block();
        drive(0, 0, 1, 0, 0);
        chk("R6 empty after draining", int'(valid_cnt), 0);
        chk("R3 no grant when empty", int'(rd_gnt), 0);
        tick();
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk("R9 protocol error sticky", int'(wr_sts[1]), 1);
        tick();

        // Scenario B: flow control off, base near the RAM top, overrun.
        do_reset(16340, 47, 15, 1'b0);
        for (int i = 0; i < 4; i++) wr_block();
        drive(0, 0, 0, 0, 0);
        chk("R8 overflow flagged", int'(wr_sts[2]), 1);
        chk("R8 oldest block dropped", int'(rd_addr), (16340 + 16) % 16384);
        chk("R8 still full", int'(valid_cnt), 48);
        tick();
        for (int i = 0; i < 3; i++) rd_block();
        wr_block();
        step(0, 0, 0, 0, 0);

        // Scenario C: geometry checks.
        do_reset(0, 95, 47, 1'b1);  // two blocks only
        step(0, 0, 0, 0, 0);
        do_reset(0, 95, 24, 1'b1);  // not a whole multiple
        step(0, 0, 0, 0, 0);
        do_reset(5, 8191, 511, 1'b1);
        drive(0, 0, 0, 0, 0);
        chk("R10 large geometry legal", int'(cfg_ok), 1);
        tick();
        wr_block();
        rd_block();
        step(0, 0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule